// File: doc/BRIEF.md
# Outbound Audio Slot Gate

This block sits between the per-slot transmit FIFOs of an audio serial-link controller and the frame serializer that drives the controller-to-codec data line. For each outbound data slot (slots 3 through 12 of a frame, mapped here to local indices 0 to 9), the serializer asks the gate what to place in that slot. The gate answers one cycle later with a 20-bit payload, a slot-valid tag and, when FIFO data is consumed, a one-hot pop strobe back to the FIFO of that slot.

The answer depends on three things. The first is whether software has enabled the slot for transmission. The second is the codec's throttle request for the slot. Codecs doing sample-rate conversion send these requests in the previous inbound frame, and the gate captures the whole request vector at the end of that frame. The third is whether the slot's FIFO holds a word. An enabled slot that the codec asks for but that has an empty FIFO sends zeros and raises a sticky underflow flag. The flag stays set until software clears it. Zero-fill ends by itself as soon as the FIFO has data again.

Top module: `tx_slot_gate`

## Requirements
- R1: After reset, `slot_vld_o`, `slot_tag_o`, `slot_word_o`, `fifo_pop_o` and `uf_o` are all zero, and the latched throttle vector is all zero (every slot requested).
- R2: `throttle_i` is captured only in a cycle with `frame_end_i` high. Changes on `throttle_i` without `frame_end_i` have no effect on later slot decisions.
- R3: A request for an in-range slot that is enabled, not throttled and has a non-empty FIFO gives `slot_tag_o`=1 one cycle later. In that cycle, `slot_word_o` equals bits [20*i+19:20*i] of `fifo_data_i` for local index i, and `fifo_pop_o` has only bit i set.
- R4: A request for an enabled slot whose latched throttle bit is 1 gives a zero payload, tag 0 and no pop. The underflow flag is not set, even when the FIFO is empty.
- R5: A request for a slot whose `slot_en_i` bit is 0 gives a zero payload, tag 0, no pop and no underflow, whatever the throttle bit and FIFO state.
- R6: A request for an enabled, non-throttled slot with an empty FIFO gives a zero payload, tag 0 and no pop, and sets `uf_o` bit i one cycle later.
- R7: An `uf_o` bit stays set until its `uf_clr_i` bit is 1. A new underflow on that slot in the same cycle as a clear leaves the bit set. A clear for another slot does not affect it.
- R8: Zero-fill stops as soon as the FIFO is non-empty: the next request to that slot carries FIFO data with tag 1.
- R9: `slot_vld_o` is high exactly one cycle after each `slot_req_i`. With no request, `fifo_pop_o` stays zero. A request with `slot_idx_i` of 10 or more is treated like a disabled slot (zero payload, tag 0, no pop, no underflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end_i | input | 1 | End of an inbound frame; captures `throttle_i` |
| throttle_i | input | 10 | Per-slot throttle requests from the codec, 1 = send nothing |
| slot_en_i | input | 10 | Per-slot transmit enable from configuration |
| fifo_empty_i | input | 10 | Per-slot FIFO empty flags |
| fifo_data_i | input | 200 | FIFO head words, slot i in bits [20*i+19:20*i] |
| slot_req_i | input | 1 | Serializer asks for the payload of one slot |
| slot_idx_i | input | 4 | Local slot index of the request (0 = slot 3) |
| uf_clr_i | input | 10 | Write-one-to-clear for the underflow flags |
| slot_vld_o | output | 1 | Response to the request of the previous cycle |
| slot_word_o | output | 20 | Slot payload, zero unless tagged |
| slot_tag_o | output | 1 | Slot carries FIFO data in this frame |
| fifo_pop_o | output | 10 | One-hot pop to the FIFO that supplied data |
| uf_o | output | 10 | Sticky per-slot underflow flags |

## Verification
A wrong latched throttle vector first shows up on the next request after a frame boundary. Tag and pop then disagree with the bench's expected value one cycle after that request, and stay wrong until the following `frame_end_i`. A wrong decision between underflow and throttle shows up one cycle after the request, either as a `uf_o` bit that is missing or one that should not be there. That bit stays wrong until it is cleared, so a check several cycles later still catches it. A broken pop index pops another slot's FIFO, and the bench sees a one-hot value on `fifo_pop_o` that does not match `slot_word_o`.

// File: rtl/tx_slot_gate_pkg.sv
package tx_slot_gate_pkg;

    typedef enum logic [1:0] {
        GATE_SEND      = 2'd0,
        GATE_UNDERFLOW = 2'd1,
        GATE_MUTED     = 2'd2,
        GATE_OFF       = 2'd3
    } gate_e;

endpackage

// File: rtl/tx_slot_gate_sel.sv
module tx_slot_gate_sel
    import tx_slot_gate_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int SLOT_W    = 20,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [NUM_SLOTS-1:0]        en_i,
    input  logic [NUM_SLOTS-1:0]        throttle_i,
    input  logic [NUM_SLOTS-1:0]        empty_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] data_i,
    output logic                        in_range_o,
    output logic [IDX_W-1:0]            safe_idx_o,
    output logic [SLOT_W-1:0]           word_o,
    output gate_e                       gate_o
);

    logic [SLOT_W-1:0] words [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_word
        assign words[g] = data_i[g*SLOT_W +: SLOT_W];
    end

    always_comb begin
        in_range_o = (int'(idx_i) < NUM_SLOTS);
        safe_idx_o = in_range_o ? idx_i : '0;
        word_o     = words[safe_idx_o];
        if (!in_range_o || !en_i[safe_idx_o]) begin
            gate_o = GATE_OFF;
        end else if (throttle_i[safe_idx_o]) begin
            gate_o = GATE_MUTED;
        end else if (empty_i[safe_idx_o]) begin
            gate_o = GATE_UNDERFLOW;
        end else begin
            gate_o = GATE_SEND;
        end
    end

endmodule

// File: rtl/tx_slot_gate_uf.sv
module tx_slot_gate_uf #(
    parameter int NUM_SLOTS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] set_i,
    input  logic [NUM_SLOTS-1:0] clr_i,
    output logic [NUM_SLOTS-1:0] flag_o
);

    logic [NUM_SLOTS-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // Flags kept through a cycle without a clear must still be set.
    assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i)));

    // A set in the same cycle as a clear wins.
    assert_uf_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/tx_slot_gate.sv
module tx_slot_gate
    import tx_slot_gate_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int SLOT_W    = 20,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_end_i,
    input  logic [NUM_SLOTS-1:0]        throttle_i,
    input  logic [NUM_SLOTS-1:0]        slot_en_i,
    input  logic [NUM_SLOTS-1:0]        fifo_empty_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] fifo_data_i,
    input  logic                        slot_req_i,
    input  logic [IDX_W-1:0]            slot_idx_i,
    input  logic [NUM_SLOTS-1:0]        uf_clr_i,
    output logic                        slot_vld_o,
    output logic [SLOT_W-1:0]           slot_word_o,
    output logic                        slot_tag_o,
    output logic [NUM_SLOTS-1:0]        fifo_pop_o,
    output logic [NUM_SLOTS-1:0]        uf_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] thr;
        logic                 vld;
        logic [SLOT_W-1:0]    word;
        logic                 tag;
        logic [NUM_SLOTS-1:0] pop;
    } state_t;

    state_t               st_d, st_q;
    logic [NUM_SLOTS-1:0] uf_set_d;
    logic                 in_range;
    logic [IDX_W-1:0]     safe_idx;
    logic [SLOT_W-1:0]    sel_word;
    gate_e                gate;

    tx_slot_gate_sel #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_sel (
        .idx_i      (slot_idx_i),
        .en_i       (slot_en_i),
        .throttle_i (st_q.thr),
        .empty_i    (fifo_empty_i),
        .data_i     (fifo_data_i),
        .in_range_o (in_range),
        .safe_idx_o (safe_idx),
        .word_o     (sel_word),
        .gate_o     (gate)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = slot_req_i;
        st_d.word = '0;
        st_d.tag  = 1'b0;
        st_d.pop  = '0;
        uf_set_d  = '0;
        if (frame_end_i) begin
            st_d.thr = throttle_i;
        end
        if (slot_req_i) begin
            unique case (gate)
                GATE_SEND: begin
                    st_d.word          = sel_word;
                    st_d.tag           = 1'b1;
                    st_d.pop[safe_idx] = 1'b1;
                end
                GATE_UNDERFLOW: uf_set_d[safe_idx] = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tx_slot_gate_uf #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_uf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (uf_set_d),
        .clr_i  (uf_clr_i),
        .flag_o (uf_o)
    );

    assign slot_vld_o  = st_q.vld;
    assign slot_word_o = st_q.word;
    assign slot_tag_o  = st_q.tag;
    assign fifo_pop_o  = st_q.pop;

    assert_pop_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop_o));

    assert_tag_matches_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tag_o == (fifo_pop_o != '0));

    assert_throttled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_i && in_range && slot_en_i[safe_idx] && st_q.thr[safe_idx])
        |=> (!slot_tag_o && fifo_pop_o == '0 && slot_word_o == '0));

    assert_disabled_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_i && in_range && !slot_en_i[safe_idx])
        |=> (!slot_tag_o && slot_word_o == '0 && fifo_pop_o == '0));

    assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_i && in_range && slot_en_i[safe_idx] && !st_q.thr[safe_idx]
         && fifo_empty_i[safe_idx])
        |=> (uf_o[$past(safe_idx)] && !slot_tag_o));

    assert_vld_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_i |=> slot_vld_o);

    assert_no_pop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld_o |-> (fifo_pop_o == '0));

endmodule

// File: tb/tx_slot_gate_bench.sv
module tx_slot_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 10;
    localparam int W          = 20;
    localparam int NV         = 8;

    typedef struct packed {
        logic [3:0]   idx;
        logic         en;
        logic         thr;
        logic         emp;
        logic [W-1:0] word;
        logic         exp_tag;
        logic         exp_uf;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd0,  1'b1, 1'b0, 1'b0, 20'h12345, 1'b1, 1'b0},
        '{4'd9,  1'b1, 1'b0, 1'b0, 20'hABCDE, 1'b1, 1'b0},
        '{4'd4,  1'b1, 1'b1, 1'b0, 20'h55555, 1'b0, 1'b0},
        '{4'd4,  1'b1, 1'b1, 1'b1, 20'h0F0F0, 1'b0, 1'b0},
        '{4'd2,  1'b0, 1'b0, 1'b0, 20'h77777, 1'b0, 1'b0},
        '{4'd2,  1'b0, 1'b1, 1'b1, 20'h88888, 1'b0, 1'b0},
        '{4'd7,  1'b1, 1'b0, 1'b1, 20'h31415, 1'b0, 1'b1},
        '{4'd12, 1'b1, 1'b0, 1'b0, 20'h99999, 1'b0, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_end_i = 1'b0;
    logic [N-1:0]   throttle_i = '0;
    logic [N-1:0]   slot_en_i = '0;
    logic [N-1:0]   fifo_empty_i = '1;
    logic [N*W-1:0] fifo_data_i = '0;
    logic           slot_req_i = 1'b0;
    logic [3:0]     slot_idx_i = '0;
    logic [N-1:0]   uf_clr_i = '0;
    logic           slot_vld_o;
    logic [W-1:0]   slot_word_o;
    logic           slot_tag_o;
    logic [N-1:0]   fifo_pop_o;
    logic [N-1:0]   uf_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_slot_gate u_tx_slot_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_end_i  (frame_end_i),
        .throttle_i   (throttle_i),
        .slot_en_i    (slot_en_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .slot_req_i   (slot_req_i),
        .slot_idx_i   (slot_idx_i),
        .uf_clr_i     (uf_clr_i),
        .slot_vld_o   (slot_vld_o),
        .slot_word_o  (slot_word_o),
        .slot_tag_o   (slot_tag_o),
        .fifo_pop_o   (fifo_pop_o),
        .uf_o         (uf_o)
    );

    function automatic string vreq(int i);
        case (i)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5:    return "R5";
            6:       return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic latch_frame(logic [N-1:0] thr);
        @(negedge clk);
        throttle_i  = thr;
        frame_end_i = 1'b1;
        @(negedge clk);
        frame_end_i = 1'b0;
    endtask

    // Request one slot; outputs are sampled at the following negedge.
    task automatic request(logic [3:0] idx, logic [N-1:0] clr);
        @(negedge clk);
        slot_req_i = 1'b1;
        slot_idx_i = idx;
        uf_clr_i   = clr;
        @(negedge clk);
        slot_req_i = 1'b0;
        uf_clr_i   = '0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        uf_clr_i = '1;
        @(negedge clk);
        uf_clr_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "vld", 32'(slot_vld_o), 0);
        chk("R1", "tag", 32'(slot_tag_o), 0);
        chk("R1", "word", 32'(slot_word_o), 0);
        chk("R1", "pop", 32'(fifo_pop_o), 0);
        chk("R1", "uf", 32'(uf_o), 0);
        rst_n = 1'b1;

        // R1: throttle vector resets to zero, so an enabled slot sends.
        slot_en_i    = '1;
        fifo_empty_i = '0;
        for (int s = 0; s < N; s++) fifo_data_i[s*W +: W] = 20'(32'h10000 + s);
        request(4'd5, '0);
        chk("R1", "tag after reset", 32'(slot_tag_o), 1);
        chk("R1", "word after reset", 32'(slot_word_o), 32'h10005);

        // Table of vectors
        for (int v = 0; v < NV; v++) begin
            clear_all();
            slot_en_i    = {N{VEC[v].en}};
            fifo_empty_i = {N{VEC[v].emp}};
            for (int s = 0; s < N; s++) fifo_data_i[s*W +: W] = VEC[v].word;
            latch_frame({N{VEC[v].thr}});
            request(VEC[v].idx, '0);
            chk(vreq(v), "vld", 32'(slot_vld_o), 1);
            chk(vreq(v), "tag", 32'(slot_tag_o), 32'(VEC[v].exp_tag));
            chk(vreq(v), "word", 32'(slot_word_o), VEC[v].exp_tag ? 32'(VEC[v].word) : 0);
            chk(vreq(v), "pop", 32'(fifo_pop_o),
                VEC[v].exp_tag ? (32'd1 << VEC[v].idx) : 0);
            chk(vreq(v), "uf", 32'(uf_o),
                VEC[v].exp_uf ? (32'd1 << VEC[v].idx) : 0);
        end

        // R2: throttle input changes without frame end are ignored
        clear_all();
        slot_en_i    = '1;
        fifo_empty_i = '0;
        latch_frame('1);
        @(negedge clk);
        throttle_i = '0;
        request(4'd3, '0);
        chk("R2", "tag held throttle", 32'(slot_tag_o), 0);
        latch_frame('0);
        request(4'd3, '0);
        chk("R2", "tag after new frame", 32'(slot_tag_o), 1);
        chk("R2", "pop after new frame", 32'(fifo_pop_o), 32'h8);

        // R9: idle cycle, no pop
        @(negedge clk);
        chk("R9", "idle vld", 32'(slot_vld_o), 0);
        chk("R9", "idle pop", 32'(fifo_pop_o), 0);

        // R7: sticky underflow
        clear_all();
        fifo_empty_i = '1;
        request(4'd5, '0);
        repeat (4) @(negedge clk);
        chk("R7", "uf held", 32'(uf_o), 32'h20);
        request(4'd1, 10'h040);
        chk("R7", "other clear", 32'(uf_o), 32'h22);
        request(4'd5, 10'h020);
        chk("R7", "set beats clear", 32'(uf_o), 32'h22);
        @(negedge clk);
        uf_clr_i = 10'h020;
        @(negedge clk);
        uf_clr_i = '0;
        chk("R7", "cleared", 32'(uf_o), 32'h02);

        // R8: zero fill ends once FIFO has data
        request(4'd1, '0);
        chk("R8", "zero fill tag", 32'(slot_tag_o), 0);
        chk("R8", "zero fill word", 32'(slot_word_o), 0);
        fifo_empty_i = '0;
        fifo_data_i[1*W +: W] = 20'hC0FFE;
        request(4'd1, '0);
        chk("R8", "resumed tag", 32'(slot_tag_o), 1);
        chk("R8", "resumed word", 32'(slot_word_o), 32'hC0FFE);
        chk("R8", "resumed pop", 32'(fifo_pop_o), 32'h2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule